// File: doc/BRIEF.md
# Shared-Memory Port Arbiter with Atomic Exchange

This block lets several cores share one small word-addressed memory. Each core presents requests on a valid/ready channel. A request carries an opcode, an address and write data. Results come back on a one-cycle response pulse with read data. The block serves plain loads and stores. It also serves an atomic exchange, which reads a word and writes the requester's new value in its place. The requester gets back the word the location held before the exchange.

An exchange occupies the memory for two cycles: a read cycle, then a write cycle. During the write cycle no other request is accepted, so no other core's access can land between the two halves. Software can build a spin lock on top of this: it swaps 1 into a location where 0 means free and 1 means held. Only the core that gets 0 back owns the lock. Simultaneous requests are granted round-robin.

Top module: `xchg_mem_arbiter`

## Requirements
- R1: While reset is asserted, no `req_ready` and no `resp_valid` bit is high. After reset every memory word reads as zero.
- R2: A load (opcode 2'b00, or the spare code 2'b11) accepted in cycle T raises `resp_valid` for that core only in cycle T+1. The response carries the addressed word.
- R3: A store (opcode 2'b01) accepted in cycle T writes the word. Its response appears in T+1 and carries the written value. Later loads from any core return that value.
- R4: An exchange (opcode 2'b10) accepted in cycle T responds in cycle T+2 with the word held before the exchange. It leaves the supplied value in the location.
- R5: In the cycle after an exchange is accepted, no request from any core is accepted. A request held off this way is accepted afterwards and sees the exchanged value.
- R6: At most one `req_ready` bit is high in any cycle, and only for a core whose `req_valid` is high.
- R7: Among waiting cores, the grant goes to the first one after the last granted core, counting upward with wraparound. After reset the search starts at core 0.
- R8: When several cores exchange 1 into the same location holding 0, exactly one of them receives 0.
- R9: Exchanging 1 into a location holding 1 returns 1 and leaves the location at 1.
- R10: At most one `resp_valid` bit is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NCORE | Request present, one bit per core |
| req_ready | output | NCORE | Request accepted this cycle, one bit per core |
| req_op | input | 2*NCORE | Opcode per core: 00 load, 01 store, 10 exchange, 11 load |
| req_addr | input | AW*NCORE | Word address per core |
| req_wdata | input | DW*NCORE | Store or exchange data per core |
| resp_valid | output | NCORE | One-cycle response pulse per core |
| resp_rdata | output | DW*NCORE | Response data per core, valid with its pulse |

## Verification
The bench starts with single-core sequences in which a store from one core is read by a load from another. These separate a working write path from a stale read. An exchange is then followed by a load, which shows that the old word went back to the requester and the new word stayed in memory. Next, a load is raised during an exchange's write cycle. This shows whether the arbiter really holds it off, and whether the load then sees the exchanged value rather than the old one. Finally, all cores exchange 1 into a free lock at once. This exposes lost atomicity, because more than one core would receive 0. The same scenario exposes a broken rotation through the order of the grants.

// File: rtl/xchg_mem_arbiter.sv
module xchg_mem_arbiter #(
  parameter int NCORE = 3,
  parameter int AW    = 4,
  parameter int DW    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NCORE-1:0]    req_valid,
  output logic [NCORE-1:0]    req_ready,
  input  logic [2*NCORE-1:0]  req_op,
  input  logic [AW*NCORE-1:0] req_addr,
  input  logic [DW*NCORE-1:0] req_wdata,
  output logic [NCORE-1:0]    resp_valid,
  output logic [DW*NCORE-1:0] resp_rdata
);
  localparam int DEPTH = 1 << AW;
  localparam int IW = (NCORE > 1) ? $clog2(NCORE) : 1;
  localparam logic [1:0] OP_STORE = 2'b01;
  localparam logic [1:0] OP_XCHG  = 2'b10;

  logic [DW-1:0] mem [DEPTH];
  logic          busy;
  logic [IW-1:0] last, sel, hold_core;
  logic [AW-1:0] hold_addr;
  logic [DW-1:0] hold_new, hold_old;
  logic          any, accept;

  always_comb begin
    any = 1'b0;
    sel = last;
    for (int k = 1; k <= NCORE; k++) begin
      int c;
      c = (int'(last) + k) % NCORE;
      if (!any && req_valid[c]) begin
        any = 1'b1;
        sel = IW'(c);
      end
    end
  end

  assign accept    = rst_n && any && !busy;
  assign req_ready = accept ? (NCORE'(1) << sel) : '0;

  wire [1:0]    g_op    = req_op[2*sel +: 2];
  wire [AW-1:0] g_addr  = req_addr[AW*sel +: AW];
  wire [DW-1:0] g_wdata = req_wdata[DW*sel +: DW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      last       <= IW'(NCORE - 1);
      hold_core  <= '0;
      hold_addr  <= '0;
      hold_new   <= '0;
      hold_old   <= '0;
      resp_valid <= '0;
      resp_rdata <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      resp_valid <= '0;
      if (busy) begin
        mem[hold_addr]                   <= hold_new;
        busy                             <= 1'b0;
        resp_valid[hold_core]            <= 1'b1;
        resp_rdata[DW*hold_core +: DW]   <= hold_old;
      end else if (accept) begin
        last <= sel;
        if (g_op == OP_XCHG) begin
          busy      <= 1'b1;
          hold_core <= sel;
          hold_addr <= g_addr;
          hold_new  <= g_wdata;
          hold_old  <= mem[g_addr];
        end else if (g_op == OP_STORE) begin
          mem[g_addr]              <= g_wdata;
          resp_valid[sel]          <= 1'b1;
          resp_rdata[DW*sel +: DW] <= g_wdata;
        end else begin
          resp_valid[sel]          <= 1'b1;
          resp_rdata[DW*sel +: DW] <= mem[g_addr];
        end
      end
    end
  end
endmodule

// File: rtl/xchg_mem_arbiter_chk.sv
module xchg_mem_arbiter_chk #(
  parameter int NCORE = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NCORE-1:0]   req_valid,
  input logic [NCORE-1:0]   req_ready,
  input logic [2*NCORE-1:0] req_op,
  input logic [NCORE-1:0]   resp_valid
);
  logic [NCORE-1:0] acc;
  logic xchg_acc, plain_acc;

  assign acc = req_valid & req_ready;

  always_comb begin
    xchg_acc  = 1'b0;
    plain_acc = 1'b0;
    for (int i = 0; i < NCORE; i++) begin
      if (acc[i]) begin
        if (req_op[2*i +: 2] == 2'b10) xchg_acc = 1'b1;
        else plain_acc = 1'b1;
      end
    end
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(req_ready)); // R6
  AST_GRANT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n) (req_ready & ~req_valid) == '0); // R6
  AST_XCHG_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n) xchg_acc |=> req_ready == '0); // R5
  AST_PLAIN_RESP: assert property (@(posedge clk) disable iff (!rst_n) plain_acc |=> resp_valid == $past(acc)); // R2
  AST_XCHG_RESP: assert property (@(posedge clk) disable iff (!rst_n) xchg_acc |=> ##1 resp_valid == $past(acc, 2)); // R4
  AST_ONE_RESP: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(resp_valid)); // R10
endmodule

bind xchg_mem_arbiter xchg_mem_arbiter_chk #(.NCORE(NCORE)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .resp_valid(resp_valid)
);

// File: tb/test_xchg_mem_arbiter.sv
module test_xchg_mem_arbiter;
  localparam int NC = 3;
  localparam int AW = 4;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NC-1:0]    req_valid = '0;
  logic [NC-1:0]    req_ready;
  logic [2*NC-1:0]  req_op = '0;
  logic [AW*NC-1:0] req_addr = '0;
  logic [DW*NC-1:0] req_wdata = '0;
  logic [NC-1:0]    resp_valid;
  logic [DW*NC-1:0] resp_rdata;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  xchg_mem_arbiter #(.NCORE(NC), .AW(AW), .DW(DW)) i_xchg_mem_arbiter (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input int c, input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    req_valid[c] = 1'b1;
    req_op[2*c +: 2] = op;
    req_addr[AW*c +: AW] = a;
    req_wdata[DW*c +: DW] = d;
  endtask

  task automatic do_op(input int c, input logic [1:0] op, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, output int rd, output int lat);
    logic r;
    @(negedge clk);
    drive(c, op, a, d);
    forever begin
      #4;
      r = req_ready[c];
      @(posedge clk);
      if (r) break;
      @(negedge clk);
    end
    @(negedge clk);
    req_valid[c] = 1'b0;
    lat = 1;
    while (!resp_valid[c] && lat < 6) begin
      @(negedge clk);
      lat++;
    end
    rd = int'(resp_rdata[DW*c +: DW]);
  endtask

  task automatic t_reset;
    int rd, lat;
    drive(0, 2'b00, 4'd0, 8'd0);
    #23;
    chk("R1 ready in reset", int'(req_ready), 0);
    chk("R1 resp in reset", int'(resp_valid), 0);
    req_valid = '0;
    @(negedge clk);
    rst_n = 1'b1;
    do_op(0, 2'b00, 4'd0, 8'd0, rd, lat);
    chk("R1 word 0 after reset", rd, 0);
    do_op(1, 2'b00, 4'd7, 8'd0, rd, lat);
    chk("R1 word 7 after reset", rd, 0);
    do_op(2, 2'b00, 4'd15, 8'd0, rd, lat);
    chk("R1 word 15 after reset", rd, 0);
  endtask

  task automatic t_store_load;
    int rd, lat;
    do_op(1, 2'b01, 4'd3, 8'h5A, rd, lat);
    chk("R3 store latency", lat, 1);
    chk("R3 store resp data", rd, 'h5A);
    do_op(2, 2'b00, 4'd3, 8'h00, rd, lat);
    chk("R2 load latency", lat, 1);
    chk("R3 cross-core load", rd, 'h5A);
    do_op(0, 2'b11, 4'd3, 8'hFF, rd, lat);
    chk("R2 spare code loads", rd, 'h5A);
  endtask

  task automatic t_xchg;
    int rd, lat;
    do_op(0, 2'b01, 4'd9, 8'h11, rd, lat);
    do_op(1, 2'b10, 4'd9, 8'h22, rd, lat);
    chk("R4 xchg latency", lat, 2);
    chk("R4 xchg returns old", rd, 'h11);
    do_op(2, 2'b00, 4'd9, 8'h00, rd, lat);
    chk("R4 xchg leaves new", rd, 'h22);
  endtask

  task automatic t_lock_busy;
    int rd, lat;
    do_op(2, 2'b10, 4'd6, 8'd1, rd, lat);
    chk("R9 free lock returns 0", rd, 0);
    do_op(0, 2'b10, 4'd6, 8'd1, rd, lat);
    chk("R9 busy lock returns 1", rd, 1);
    do_op(1, 2'b00, 4'd6, 8'd0, rd, lat);
    chk("R9 busy lock stays 1", rd, 1);
  endtask

  task automatic t_holdoff;
    @(negedge clk);
    drive(0, 2'b10, 4'd12, 8'h77);
    #4;
    chk("R5 xchg granted", int'(req_ready), 1);
    @(posedge clk);
    @(negedge clk);
    req_valid[0] = 1'b0;
    drive(1, 2'b00, 4'd12, 8'h00);
    #4;
    chk("R5 nothing granted in write cycle", int'(req_ready), 0);
    @(posedge clk);
    @(negedge clk);
    chk("R4 xchg resp pulse", int'(resp_valid), 1);
    chk("R4 xchg old value", int'(resp_rdata[0 +: DW]), 0);
    #4;
    chk("R5 held load granted", int'(req_ready), 2);
    @(posedge clk);
    @(negedge clk);
    req_valid[1] = 1'b0;
    chk("R10 single response", int'(resp_valid), 2);
    chk("R5 held load sees new value", int'(resp_rdata[DW +: DW]), 'h77);
  endtask

  task automatic t_contend;
    int order[3];
    int got[NC];
    int ng = 0;
    int pend = -1;
    int zeros = 0;
    int rd, lat;
    for (int c = 0; c < NC; c++) got[c] = -1;
    @(negedge clk);
    for (int c = 0; c < NC; c++) drive(c, 2'b10, 4'd13, 8'd1);
    for (int cyc = 0; cyc < 9; cyc++) begin
      if (cyc > 0) @(negedge clk);
      if (pend >= 0) begin
        req_valid[pend] = 1'b0;
        pend = -1;
      end
      for (int c = 0; c < NC; c++)
        if (resp_valid[c]) got[c] = int'(resp_rdata[DW*c +: DW]);
      chk("R10 at most one response", int'($countones(resp_valid) <= 1), 1);
      #4;
      chk("R6 at most one grant", int'($countones(req_ready) <= 1), 1);
      for (int c = 0; c < NC; c++)
        if (req_ready[c] && ng < 3) begin
          order[ng] = c;
          ng++;
          pend = c;
        end
      @(posedge clk);
    end
    @(negedge clk);
    chk("R7 all cores granted", ng, 3);
    if (ng == 3) begin
      chk("R7 rotation first step", order[1], (order[0] + 1) % NC);
      chk("R7 rotation second step", order[2], (order[1] + 1) % NC);
    end
    for (int c = 0; c < NC; c++) begin
      chk("R8 every core answered", int'(got[c] >= 0), 1);
      if (got[c] == 0) zeros++;
    end
    chk("R8 exactly one winner", zeros, 1);
    do_op(0, 2'b00, 4'd13, 8'd0, rd, lat);
    chk("R8 lock left held", rd, 1);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_store_load();
    t_xchg();
    t_lock_busy();
    t_holdoff();
    t_contend();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule